// File: doc/BRIEF.md
# Stepwise Micro-Operation Integer Divider

This block is an unsigned integer divider that a microcode sequencer drives one micro-operation at a time; it does not run a divide on its own. The sequencer first issues a start operation carrying the upper part of the dividend and the divisor. The block saves the divisor, zeroes its quotient and takes one partial division step. The sequencer then issues step operations. Each step carries the lower part of the dividend and a count of how many of its bits are still to be consumed. The block shifts those bits into its partial remainder, performs one normalising subtraction, and returns the updated count. The sequencer repeats the step until the returned count is zero. Two read operations then return the quotient and the remainder.

Every command takes one clock. The quotient, remainder and divisor are held in internal registers between commands. Any value written to a destination is merged into the caller's old destination value at a selectable operand size. A divisor of zero raises a one-cycle error and leaves the state untouched. Because a step with a count of zero changes nothing, an unrolled sequence may issue more steps than it needs.

Top module: `stepdiv_unit`

## Requirements
- R1: After reset the quotient, remainder and saved divisor are zero. The outputs `res_valid`, `res_data`, `zf_wr`, `zf_val` and `div_err` are all low.
- R2: Opcode 0 (start) with a nonzero `src_b` does the following. It zeroes the quotient, loads the remainder from `src_a` and saves `src_b` as the divisor. It then applies one basic step. The basic step does nothing if the divisor exceeds the remainder. Otherwise it aligns the divisor's highest set bit with the remainder's highest set bit. If the aligned divisor is then too large, it moves back by one position. It adds the matching power of two to the quotient and subtracts the aligned divisor from the remainder. For example, 100 divided by 7 gives quotient 8 and remainder 44. The start command produces no result.
- R3: A divisor of zero raises `div_err` for exactly one cycle, with no result and no change of state. This covers a start command with `src_b` equal to 0. It also covers a step command with a nonzero count while the saved divisor is 0.
- R4: Opcode 1 (step) takes its count from `src_b`, saturated to W. With a count of zero, the quotient, remainder and divisor stay unchanged.
- R5: A step works in two phases. First, while the remainder is below the divisor and the count is nonzero, it repeats three actions. It doubles the remainder and inserts bit (count-1) of `src_a`. It doubles the quotient. It decrements the count. Second, it applies one basic step. If the remainder already equals or exceeds the divisor, the first phase does nothing. A start command with high part H < D, followed by steps until the count is 0, leaves quotient and remainder equal to {H,L}/D and {H,L}%D.
- R6: A step returns its remaining count in `res_data`, merged at the command size, with `res_valid` high.
- R7: `zf_wr` is high only for a step issued with `cmd_zf_en` set. `zf_val` is then 1 when the remaining count is 0 and 0 otherwise.
- R8: Opcode 2 returns the quotient and opcode 3 returns the remainder, merged at the command size. Neither changes any state.
- R9: Merging works by size code. Code 0 replaces bits 7:0 and code 1 replaces bits 15:0 of `dst_in`, keeping the upper bits of `dst_in`. Code 2 replaces bits 31:0 and clears the upper bits. Code 3 replaces the whole word.
- R10: The outputs are registered and reflect a command on the clock edge that accepts it. With `cmd_valid` low, the next cycle shows no result and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 start, 1 step, 2 read quotient, 3 read remainder |
| cmd_size | input | 2 | Merge size code (8/16/32/W bits) |
| cmd_zf_en | input | 1 | Step also reports the zero flag |
| src_a | input | W | Start: upper dividend; step: lower dividend bits |
| src_b | input | W | Start: divisor; step: remaining bit count |
| dst_in | input | W | Old destination value for merging |
| res_valid | output | 1 | `res_data` is a result |
| res_data | output | W | Merged result |
| zf_wr | output | 1 | Zero flag is being written |
| zf_val | output | 1 | Zero flag value |
| div_err | output | 1 | Divide-by-zero error pulse |

## Verification
Within a single step command, the bit-pulling loop and the final subtraction act in the same cycle. The count can run out in that same cycle. The bench provokes this by choosing the remainder, divisor and low bits so that the last pulled bit pushes the remainder past the divisor. It then checks three things: the returned count is zero, the zero flag is set, and the quotient read back already holds the new low bit. It also issues a step whose remainder already exceeds the divisor, so the loop is skipped and only the subtraction happens. It checks the returned count and both state registers against hand-computed values.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STEP  = 2'd1,
    OP_RDQ   = 2'd2,
    OP_RDR   = 2'd3
  } sd_op_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_ALL = 2'd3
  } sd_size_e;
endpackage

// File: rtl/stepdiv_normstep.sv
// One normalising subtraction: align divisor msb to dividend msb,
// back off one place if too large, subtract and report the weight.
module stepdiv_normstep #(
  parameter int W = 64
) (
  input  logic [W:0]   dd,
  input  logic [W:0]   dv,
  output logic [W-1:0] inc,
  output logic [W-1:0] rem_out
);
  localparam int N  = W + 1;
  localparam int SW = $clog2(N) + 1;

  function automatic logic [SW-1:0] top_bit(input logic [N-1:0] v);
    logic [SW-1:0] p;
    p = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) p = SW'(i);
    end
    return p;
  endfunction

  logic [SW-1:0] sh;
  logic [N-1:0]  aligned;
  logic [W-1:0]  weight;

  always_comb begin
    sh      = top_bit(dd) - top_bit(dv);
    aligned = dv << sh;
    weight  = W'(1) << sh;
    if (aligned > dd) begin
      aligned = aligned >> 1;
      weight  = weight >> 1;
    end
    if ((dv != '0) && (dv <= dd)) begin
      inc     = weight;
      rem_out = W'(dd - aligned);
    end else begin
      inc     = '0;
      rem_out = W'(dd);
    end
  end
endmodule

// File: rtl/stepdiv_pull_chain.sv
// Unrolled bit-pulling loop: while remainder < divisor and count != 0,
// shift in the next low-operand bit and double the quotient.
module stepdiv_pull_chain #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [W-1:0]  rem_in,
  input  logic [W-1:0]  dv,
  input  logic [W-1:0]  low,
  input  logic [W-1:0]  q_in,
  input  logic [CW-1:0] cnt_in,
  output logic [W:0]    dd_out,
  output logic [W-1:0]  q_out,
  output logic [CW-1:0] cnt_out
);
  logic [W:0]    dd_s  [0:W];
  logic [W-1:0]  q_s   [0:W];
  logic [CW-1:0] c_s   [0:W];

  assign dd_s[0] = {1'b0, rem_in};
  assign q_s[0]  = q_in;
  assign c_s[0]  = cnt_in;

  for (genvar g = 0; g < W; g++) begin : g_stage
    logic          act;
    logic          pull_bit;
    logic [CW-1:0] cm1;

    assign cm1 = c_s[g] - CW'(1);
    assign act = (c_s[g] != '0) && (dd_s[g] < {1'b0, dv});

    always_comb begin
      pull_bit = 1'b0;
      for (int k = 0; k < W; k++) begin
        if (cm1 == CW'(k)) pull_bit = low[k];
      end
    end

    assign dd_s[g+1] = act ? {dd_s[g][W-1:0], pull_bit} : dd_s[g];
    assign q_s[g+1]  = act ? {q_s[g][W-2:0], 1'b0}     : q_s[g];
    assign c_s[g+1]  = act ? cm1                        : c_s[g];
  end

  assign dd_out  = dd_s[W];
  assign q_out   = q_s[W];
  assign cnt_out = c_s[W];
endmodule

// File: rtl/stepdiv_merge.sv
module stepdiv_merge
  import stepdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] dst,
  input  logic [W-1:0] val,
  input  logic [1:0]   sz,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (sd_size_e'(sz))
      SZ_8:    res = {dst[W-1:8],  val[7:0]};
      SZ_16:   res = {dst[W-1:16], val[15:0]};
      SZ_32:   res = {{(W-32){1'b0}}, val[31:0]};
      default: res = val;
    endcase
  end
endmodule

// File: rtl/stepdiv_unit.sv
module stepdiv_unit
  import stepdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd_op,
  input  logic [1:0]   cmd_size,
  input  logic         cmd_zf_en,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] dst_in,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         zf_wr,
  output logic         zf_val,
  output logic         div_err
);
  localparam int IW = $clog2(W);
  localparam int CW = IW + 1;

  logic [W-1:0] quot_q, rem_q, dvsr_q;
  logic [W-1:0] quot_d, rem_d, dvsr_d;
  logic         state_en;

  logic         res_valid_d, zf_wr_d, zf_val_d, err_d;
  logic [W-1:0] res_data_d;

  logic [CW-1:0] step_cnt;
  logic [W:0]    ch_dd;
  logic [W-1:0]  ch_q;
  logic [CW-1:0] ch_cnt;

  logic [W:0]    ns_dd, ns_dv;
  logic [W-1:0]  ns_inc, ns_rem;

  logic [W-1:0]  mg_val, mg_res;

  sd_op_e op;
  assign op = sd_op_e'(cmd_op);

  // Count saturated to W
  assign step_cnt = (src_b > W'(W)) ? CW'(W) : src_b[CW-1:0];

  stepdiv_pull_chain #(.W(W), .CW(CW)) u_chain (
    .rem_in  (rem_q),
    .dv      (dvsr_q),
    .low     (src_a),
    .q_in    (quot_q),
    .cnt_in  (step_cnt),
    .dd_out  (ch_dd),
    .q_out   (ch_q),
    .cnt_out (ch_cnt)
  );

  assign ns_dd = (op == OP_START) ? {1'b0, src_a} : ch_dd;
  assign ns_dv = (op == OP_START) ? {1'b0, src_b} : {1'b0, dvsr_q};

  stepdiv_normstep #(.W(W)) u_norm (
    .dd      (ns_dd),
    .dv      (ns_dv),
    .inc     (ns_inc),
    .rem_out (ns_rem)
  );

  always_comb begin
    unique case (op)
      OP_RDQ:  mg_val = quot_q;
      OP_RDR:  mg_val = rem_q;
      default: mg_val = W'(ch_cnt);
    endcase
  end

  stepdiv_merge #(.W(W)) u_merge (
    .dst (dst_in),
    .val (mg_val),
    .sz  (cmd_size),
    .res (mg_res)
  );

  // Next-state and output decode
  always_comb begin
    quot_d      = quot_q;
    rem_d       = rem_q;
    dvsr_d      = dvsr_q;
    state_en    = 1'b0;
    res_valid_d = 1'b0;
    res_data_d  = '0;
    zf_wr_d     = 1'b0;
    zf_val_d    = 1'b0;
    err_d       = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_START: begin
          if (src_b == '0) begin
            err_d = 1'b1;
          end else begin
            state_en = 1'b1;
            quot_d   = ns_inc;
            rem_d    = ns_rem;
            dvsr_d   = src_b;
          end
        end
        OP_STEP: begin
          if ((step_cnt != '0) && (dvsr_q == '0)) begin
            err_d = 1'b1;
          end else begin
            state_en    = (step_cnt != '0);
            quot_d      = ch_q + ns_inc;
            rem_d       = ns_rem;
            res_valid_d = 1'b1;
            res_data_d  = mg_res;
            zf_wr_d     = cmd_zf_en;
            zf_val_d    = cmd_zf_en && (ch_cnt == '0);
          end
        end
        default: begin
          res_valid_d = 1'b1;
          res_data_d  = mg_res;
        end
      endcase
    end
  end

  // State registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      rem_q  <= '0;
      dvsr_q <= '0;
    end else if (state_en) begin
      quot_q <= quot_d;
      rem_q  <= rem_d;
      dvsr_q <= dvsr_d;
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      zf_wr     <= 1'b0;
      zf_val    <= 1'b0;
      div_err   <= 1'b0;
    end else begin
      res_valid <= res_valid_d;
      res_data  <= res_data_d;
      zf_wr     <= zf_wr_d;
      zf_val    <= zf_val_d;
      div_err   <= err_d;
    end
  end
endmodule

// File: rtl/stepdiv_unit_chk.sv
module stepdiv_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [1:0]   cmd_op,
  input logic [W-1:0] src_b,
  input logic         res_valid,
  input logic         zf_wr,
  input logic         div_err,
  input logic [W-1:0] quot_q,
  input logic [W-1:0] rem_q,
  input logic [W-1:0] dvsr_q
);
  AST_START_ZERO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && src_b == '0) |=> div_err); // R3

  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> !res_valid); // R3

  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> ($stable(quot_q) && $stable(rem_q) && $stable(dvsr_q))); // R3

  AST_ZERO_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && src_b == '0)
      |=> ($stable(quot_q) && $stable(rem_q) && $stable(dvsr_q))); // R4

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1]) |=> ($stable(quot_q) && $stable(rem_q))); // R8

  AST_ZF_NEEDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    zf_wr |-> res_valid); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!res_valid && !div_err)); // R10

  AST_START_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |=> !res_valid); // R2
endmodule

bind stepdiv_unit stepdiv_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .src_b     (src_b),
  .res_valid (res_valid),
  .zf_wr     (zf_wr),
  .div_err   (div_err),
  .quot_q    (quot_q),
  .rem_q     (rem_q),
  .dvsr_q    (dvsr_q)
);

// File: tb/stepdiv_unit_bench.sv
module stepdiv_unit_bench;
  localparam int W = 64;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_op, cmd_size;
  logic         cmd_zf_en;
  logic [W-1:0] src_a, src_b, dst_in;
  logic         res_valid, zf_wr, zf_val, div_err;
  logic [W-1:0] res_data;

  int n_run  = 0;
  int n_fail = 0;

  logic         o_v, o_zw, o_zv, o_e;
  logic [W-1:0] o_d;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stepdiv_unit #(.W(W)) u_stepdiv_unit (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_size, .cmd_zf_en,
    .src_a, .src_b, .dst_in, .res_valid, .res_data, .zf_wr, .zf_val, .div_err
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one command for one cycle; capture registered outputs after.
  task automatic issue(input logic [1:0] op, input logic [1:0] sz, input logic zfe,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_size = sz; cmd_zf_en = zfe;
    src_a = a; src_b = b; dst_in = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    o_v = res_valid; o_d = res_data; o_zw = zf_wr; o_zv = zf_val; o_e = div_err;
  endtask

  task automatic read_q(output logic [W-1:0] v);
    issue(2'd2, 2'd3, 1'b0, '0, '0, '0);
    v = o_d;
  endtask

  task automatic read_r(output logic [W-1:0] v);
    issue(2'd3, 2'd3, 1'b0, '0, '0, '0);
    v = o_d;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    chk("R1 res_valid", W'(res_valid), '0);
    chk("R1 div_err", W'(div_err), '0);
    chk("R1 zf_wr", W'(zf_wr), '0);
    read_q(v); chk("R1 quotient", v, '0);
    read_r(v); chk("R1 remainder", v, '0);
    // Step with count while divisor is zero
    issue(2'd1, 2'd3, 1'b1, 64'h5, 64'd5, '0);
    chk("R3 step div0 err", W'(o_e), 1);
    chk("R3 step div0 no result", W'(o_v), 0);
    @(negedge clk);
    chk("R10 idle no result", W'(res_valid), 0);
    chk("R10 idle no err", W'(div_err), 0);
  endtask

  task automatic t_start_and_step;
    logic [W-1:0] v;
    issue(2'd0, 2'd3, 1'b0, 64'd100, 64'd7, '0);
    chk("R2 start no result", W'(o_v), 0);
    read_q(v); chk("R2 start quotient", v, 64'd8);
    read_r(v); chk("R2 start remainder", v, 64'd44);
    // Count zero: no change
    issue(2'd1, 2'd3, 1'b1, 64'hF, 64'd0, '0);
    chk("R4 zero count result", o_d, 64'd0);
    chk("R7 zero count zf", W'({o_zw, o_zv}), 64'd3);
    read_q(v); chk("R4 quotient kept", v, 64'd8);
    read_r(v); chk("R4 remainder kept", v, 64'd44);
    // Remainder already >= divisor: no pull, one subtraction
    issue(2'd1, 2'd3, 1'b1, 64'h5, 64'd3, '0);
    chk("R6 step count", o_d, 64'd3);
    chk("R7 zf clear", W'({o_zw, o_zv}), 64'd2);
    read_q(v); chk("R5 no-pull quotient", v, 64'd12);
    read_r(v); chk("R5 no-pull remainder", v, 64'd16);
    // Start with divisor larger than dividend
    issue(2'd0, 2'd3, 1'b0, 64'd5, 64'd9, '0);
    read_q(v); chk("R2 small quotient", v, 64'd0);
    read_r(v); chk("R2 small remainder", v, 64'd5);
    // Divisor zero on start keeps state
    issue(2'd0, 2'd3, 1'b0, 64'd77, 64'd0, '0);
    chk("R3 start div0 err", W'(o_e), 1);
    chk("R3 start div0 no result", W'(o_v), 0);
    read_r(v); chk("R3 remainder kept", v, 64'd5);
  endtask

  // Count runs out in the same cycle as the final subtraction
  task automatic t_same_cycle;
    logic [W-1:0] v;
    issue(2'd0, 2'd3, 1'b0, 64'd1, 64'd3, '0);   // q=0, rem=1
    issue(2'd1, 2'd3, 1'b1, 64'b01, 64'd2, '0);  // pull 0 -> 2, pull 1 -> 5, sub
    chk("R6 exhausted count", o_d, 64'd0);
    chk("R7 exhausted zf", W'({o_zw, o_zv}), 64'd3);
    read_q(v); chk("R5 same-cycle quotient", v, 64'd1);
    read_r(v); chk("R5 same-cycle remainder", v, 64'd2);
    issue(2'd1, 2'd3, 1'b0, 64'h1, 64'd1, '0);
    chk("R7 zf disabled", W'(o_zw), 0);
  endtask

  task automatic run_div(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d);
    logic [127:0] num, eq, er;
    logic [W-1:0] cnt, v;
    num = {h, l};
    eq  = num / {64'd0, d};
    er  = num % {64'd0, d};
    issue(2'd0, 2'd3, 1'b0, h, d, '0);
    cnt = 64'd64;
    for (int i = 0; i < 70 && cnt != 0; i++) begin
      issue(2'd1, 2'd3, 1'b1, l, cnt, '0);
      cnt = o_d;
    end
    read_q(v); chk("R5 full quotient", v, eq[63:0]);
    read_r(v); chk("R5 full remainder", v, er[63:0]);
  endtask

  task automatic t_full;
    logic [W-1:0] d, h, l;
    run_div(64'd0, 64'd1000, 64'd3);
    run_div(64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    run_div(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run_div(64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 64'h8000_0000_0000_0000);
    run_div(64'd0, 64'd5, 64'd9);
    for (int i = 0; i < 20; i++) begin
      d = {$urandom(), $urandom()} >> (i * 3);
      if (d == 0) d = 64'd13;
      h = {$urandom(), $urandom()} % d;
      l = {$urandom(), $urandom()};
      run_div(h, l, d);
    end
  endtask

  task automatic t_merge;
    logic [W-1:0] ff;
    ff = 64'hFFFF_FFFF_FFFF_FFFF;
    run_div(64'd0, 64'd1000, 64'd3);   // q = 333 = 0x14D, r = 1
    issue(2'd2, 2'd0, 1'b0, '0, '0, ff);
    chk("R9 8-bit merge", o_d, 64'hFFFF_FFFF_FFFF_FF4D);
    issue(2'd2, 2'd1, 1'b0, '0, '0, ff);
    chk("R9 16-bit merge", o_d, 64'hFFFF_FFFF_FFFF_014D);
    issue(2'd2, 2'd2, 1'b0, '0, '0, ff);
    chk("R9 32-bit zero-extend", o_d, 64'h14D);
    issue(2'd3, 2'd3, 1'b0, '0, '0, ff);
    chk("R8 read remainder", o_d, 64'd1);
    issue(2'd1, 2'd0, 1'b1, 64'd0, 64'd2, ff);
    chk("R6 merged step count", o_d, 64'hFFFF_FFFF_FFFF_FF00);
    chk("R8 valid on read", W'(o_v), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_size = '0; cmd_zf_en = 1'b0;
    src_a = '0; src_b = '0; dst_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_start_and_step;
    t_same_cycle;
    t_full;
    t_merge;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule